// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Accumulator Rounding

This block is the multiply-accumulate datapath of a 32-bit processor. Each cycle it takes two register operands, an operation code, a two-bit half-select mode and a small shift amount. The multiplier is asymmetric: a signed 32-bit value times a signed 16-bit value. The mode decides which halves of the operands feed it. The signed product is aligned and sign-extended to 56 bits. It then either replaces the accumulator or is added to it, and the update completes on a single clock edge.

Two further operations work on the accumulator alone. Rounding keeps either 16 or 32 significant bits of the result field: it adds one half of the lowest kept position and then zeroes everything below it. Read-back takes a 32-bit window of the accumulator and registers it on the result port for the register file. One read-back form shifts the accumulator left by 0 to 3 places first, for digit adjustment.

Top module: `mac_acc56`

## Requirements
- R1: While reset is asserted, and on its release, the accumulator is zero, the result is zero and the result-valid flag is low.
- R2: Mode 0 multiplies the signed upper half of A (bits 31:16) by the signed upper half of B (bits 31:16). The 32-bit product is sign-extended and placed at accumulator bits 47:16.
- R3: Mode 1 multiplies the signed lower half of A (bits 15:0) by the signed lower half of B (bits 15:0). The product is placed at bits 47:16, as in R2.
- R4: Mode 2 multiplies all 32 bits of A by the upper half of B. Mode 3 multiplies all 32 bits of A by the lower half of B. All values are signed, and the 48-bit product is sign-extended into bits 55:0 without a shift.
- R5: Opcode 1 (load) writes the aligned product into the accumulator. The new value is visible after the same rising edge that samples the operands.
- R6: Opcode 2 (accumulate) adds the aligned product to the accumulator modulo 2^56, without saturation.
- R7: Opcode 4 (round to 32 bits) adds 2^15 and then clears bits 15:0. The sum wraps and is not saturated.
- R8: Opcode 3 (round to 16 bits) adds 2^31 and then clears bits 31:0. The sum wraps and is not saturated.
- R9: Opcode 5 (shifted read) sets the result to accumulator bits [47-s:16-s], where s is the 2-bit shift input. The result-valid flag is high for the following cycle, and the accumulator does not change.
- R10: Opcode 6 (low read) sets the result to accumulator bits 31:0. The result-valid flag is high for the following cycle, and the accumulator does not change.
- R11: Opcodes 0 and 7 are idle. The accumulator and the result hold, and the result-valid flag is low the next cycle, whatever the operand and mode inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| mode_i | input | 2 | Operand half-select mode |
| rd_sh_i | input | 2 | Left shift applied by the shifted read |
| src_a_i | input | 32 | Register operand A |
| src_b_i | input | 32 | Register operand B |
| res_o | output | 32 | Registered read-back result |
| res_vld_o | output | 1 | High for the cycle after a read operation |
| acc_o | output | 56 | Current accumulator value |

## Verification
A read-back and an accumulator update fall into consecutive cycles with no gap between them. The result register is loaded from the accumulator on the same edge on which the accumulator could otherwise change, so a read issued in the cycle right after a load, accumulate or round must return the value that operation just produced. The stimulus table places reads directly behind accumulates and rounds. A separate case shows that a read leaves the accumulator unchanged while the result updates. Each pair is judged against a bench model that keeps the accumulator as a plain 64-bit integer masked to 56 bits.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int MAC_DW = 32;
  localparam int MAC_HW = 16;
  localparam int MAC_AW = 56;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ACCUM = 3'd2,
    OP_RND16 = 3'd3,
    OP_RND32 = 3'd4,
    OP_RDSH  = 3'd5,
    OP_RDLO  = 3'd6,
    OP_IDLE7 = 3'd7
  } mac_op_e;

  // add half of the lowest kept position, then clear the cut bits
  function automatic logic [MAC_AW-1:0] round_at(input logic [MAC_AW-1:0] v,
                                                 input int unsigned cut);
    logic [MAC_AW-1:0] one;
    logic [MAC_AW-1:0] half;
    logic [MAC_AW-1:0] keep;
    one  = {{(MAC_AW-1){1'b0}}, 1'b1};
    half = one << (cut - 1);
    keep = ~((one << cut) - one);
    return (v + half) & keep;
  endfunction

  function automatic logic [MAC_DW-1:0] window_at(input logic [MAC_AW-1:0] v,
                                                  input logic [1:0] sh);
    return MAC_DW'((v << sh) >> MAC_HW);
  endfunction
endpackage

// File: rtl/mac_opsel.sv
module mac_opsel
  import mac_pkg::*;
#(
  parameter int DW = MAC_DW,
  parameter int HW = MAC_HW
) (
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] x_o,
  output logic [HW-1:0] y_o,
  output logic          half_o
);
  localparam int XPAD = DW - HW;

  logic [HW-1:0] a_hi, a_lo, b_hi, b_lo;
  assign a_hi = a_i[DW-1 -: HW];
  assign a_lo = a_i[HW-1:0];
  assign b_hi = b_i[DW-1 -: HW];
  assign b_lo = b_i[HW-1:0];

  always_comb begin
    half_o = 1'b0;
    x_o    = a_i;
    y_o    = b_lo;
    unique case (mode_i)
      2'd0: begin x_o = {{XPAD{a_hi[HW-1]}}, a_hi}; y_o = b_hi; half_o = 1'b1; end
      2'd1: begin x_o = {{XPAD{a_lo[HW-1]}}, a_lo}; y_o = b_lo; half_o = 1'b1; end
      2'd2: begin x_o = a_i; y_o = b_hi; end
      default: begin x_o = a_i; y_o = b_lo; end
    endcase
  end
endmodule

// File: rtl/mac_mul.sv
module mac_mul
  import mac_pkg::*;
#(
  parameter int DW = MAC_DW,
  parameter int HW = MAC_HW,
  parameter int AW = MAC_AW
) (
  input  logic [DW-1:0] x_i,
  input  logic [HW-1:0] y_i,
  input  logic          half_i,
  output logic [AW-1:0] prod_o
);
  localparam int PW = DW + HW;
  localparam int EXT = AW - PW;

  logic signed [PW-1:0] xs, ys, p;
  logic [AW-1:0] ext;

  assign xs  = $signed({{HW{x_i[DW-1]}}, x_i});
  assign ys  = $signed({{DW{y_i[HW-1]}}, y_i});
  assign p   = xs * ys;
  assign ext = {{EXT{p[PW-1]}}, p};
  assign prod_o = half_i ? (ext << HW) : ext;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int HW = MAC_HW,
  parameter int AW = MAC_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mac_op_e       op_i,
  input  logic [AW-1:0] prod_i,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_nxt;

  always_comb begin
    acc_nxt = acc_o;
    unique case (op_i)
      OP_LOAD:  acc_nxt = prod_i;
      OP_ACCUM: acc_nxt = acc_o + prod_i;
      OP_RND16: acc_nxt = round_at(acc_o, 2 * HW);
      OP_RND32: acc_nxt = round_at(acc_o, HW);
      default:  acc_nxt = acc_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_o <= '0;
    else        acc_o <= acc_nxt;
  end
endmodule

// File: rtl/mac_readout.sv
module mac_readout
  import mac_pkg::*;
#(
  parameter int DW = MAC_DW,
  parameter int AW = MAC_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mac_op_e       op_i,
  input  logic [1:0]    sh_i,
  input  logic [AW-1:0] acc_i,
  output logic [DW-1:0] res_o,
  output logic          vld_o
);
  logic          rd_fire;
  logic [DW-1:0] res_nxt;

  assign rd_fire = (op_i == OP_RDSH) || (op_i == OP_RDLO);
  assign res_nxt = (op_i == OP_RDSH) ? window_at(acc_i, sh_i) : DW'(acc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= rd_fire;
      if (rd_fire) res_o <= res_nxt;
    end
  end
endmodule

// File: rtl/mac_acc56.sv
module mac_acc56
  import mac_pkg::*;
#(
  parameter int DW = MAC_DW,
  parameter int HW = MAC_HW,
  parameter int AW = MAC_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    rd_sh_i,
  input  logic [DW-1:0] src_a_i,
  input  logic [DW-1:0] src_b_i,
  output logic [DW-1:0] res_o,
  output logic          res_vld_o,
  output logic [AW-1:0] acc_o
);
  mac_op_e       op_w;
  logic [DW-1:0] x_w;
  logic [HW-1:0] y_w;
  logic          half_w;
  logic [AW-1:0] prod_w;

  assign op_w = mac_op_e'(op_i);

  mac_opsel #(.DW(DW), .HW(HW)) u_sel (
    .mode_i(mode_i), .a_i(src_a_i), .b_i(src_b_i),
    .x_o(x_w), .y_o(y_w), .half_o(half_w)
  );

  mac_mul #(.DW(DW), .HW(HW), .AW(AW)) u_mul (
    .x_i(x_w), .y_i(y_w), .half_i(half_w), .prod_o(prod_w)
  );

  mac_accum #(.HW(HW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .op_i(op_w), .prod_i(prod_w), .acc_o(acc_o)
  );

  mac_readout #(.DW(DW), .AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .op_i(op_w), .sh_i(rd_sh_i), .acc_i(acc_o),
    .res_o(res_o), .vld_o(res_vld_o)
  );
endmodule

// File: rtl/mac_acc56_chk.sv
module mac_acc56_chk
  import mac_pkg::*;
#(
  parameter int DW = MAC_DW,
  parameter int HW = MAC_HW,
  parameter int AW = MAC_AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_i,
  input logic [AW-1:0] prod_w,
  input logic [AW-1:0] acc_o,
  input logic [DW-1:0] res_o,
  input logic          res_vld_o
);
  logic is_rd, is_idle;
  assign is_rd   = (op_i == OP_RDSH) || (op_i == OP_RDLO);
  assign is_idle = (op_i == OP_IDLE) || (op_i == OP_IDLE7);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc_o == '0) && (res_o == '0) && !res_vld_o);

  // R5
  load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_LOAD) |=> acc_o == $past(prod_w));

  // R6
  accum_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ACCUM) |=> acc_o == AW'($past(acc_o) + $past(prod_w)));

  // R7
  rnd32_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RND32) |=> acc_o[HW-1:0] == '0);

  // R8
  rnd16_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RND16) |=> acc_o[2*HW-1:0] == '0);

  // R9
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> res_vld_o && $stable(acc_o));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_idle |=> !res_vld_o && $stable(acc_o) && $stable(res_o));
endmodule

bind mac_acc56 mac_acc56_chk #(.DW(DW), .HW(HW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .prod_w(prod_w),
  .acc_o(acc_o), .res_o(res_o), .res_vld_o(res_vld_o)
);

// File: tb/tb_mac_acc56.sv
`timescale 1ns/1ps
module tb_mac_acc56;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  sh = 2'd0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res;
  logic        vld;
  logic [55:0] acc;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic [63:0] m_acc;
  logic [31:0] m_res;
  localparam logic [63:0] MASK = 64'h00FF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  mac_acc56 dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .mode_i(mode), .rd_sh_i(sh),
    .src_a_i(a), .src_b_i(b), .res_o(res), .res_vld_o(vld), .acc_o(acc)
  );

  // {op, mode, shift, A, B}
  localparam int NV = 16;
  localparam logic [70:0] VEC [NV] = '{
    {3'd1, 2'd0, 2'd0, 32'h0003_0000, 32'h0002_0000},
    {3'd2, 2'd1, 2'd0, 32'h0000_FFFB, 32'h0000_0007},
    {3'd5, 2'd0, 2'd0, 32'h0,         32'h0},
    {3'd2, 2'd2, 2'd0, 32'h1234_5678, 32'h7FFF_0000},
    {3'd2, 2'd3, 2'd0, 32'hFFFF_FF00, 32'h0000_8000},
    {3'd5, 2'd0, 2'd3, 32'h0,         32'h0},
    {3'd6, 2'd0, 2'd0, 32'h0,         32'h0},
    {3'd4, 2'd0, 2'd0, 32'h0,         32'h0},
    {3'd5, 2'd0, 2'd1, 32'h0,         32'h0},
    {3'd1, 2'd3, 2'd0, 32'h8000_0000, 32'h0000_7FFF},
    {3'd2, 2'd0, 2'd0, 32'h8000_1111, 32'h8000_2222},
    {3'd3, 2'd0, 2'd0, 32'h0,         32'h0},
    {3'd5, 2'd0, 2'd2, 32'h0,         32'h0},
    {3'd0, 2'd2, 2'd1, 32'hDEAD_BEEF, 32'hCAFE_F00D},
    {3'd1, 2'd1, 2'd0, 32'hABCD_8001, 32'h1234_FFFF},
    {3'd6, 2'd0, 2'd0, 32'h0,         32'h0}
  };

  function automatic logic [63:0] mdl_prod(input logic [1:0] md, input logic [31:0] av,
                                           input logic [31:0] bv);
    longint p;
    case (md)
      2'd0: p = longint'($signed(av[31:16])) * longint'($signed(bv[31:16])) * 65536;
      2'd1: p = longint'($signed(av[15:0]))  * longint'($signed(bv[15:0]))  * 65536;
      2'd2: p = longint'($signed(av))        * longint'($signed(bv[31:16]));
      default: p = longint'($signed(av))     * longint'($signed(bv[15:0]));
    endcase
    return 64'(p) & MASK;
  endfunction

  function automatic string tag_of(input logic [2:0] o, input logic [1:0] md);
    case (o)
      3'd1, 3'd2: begin
        if (md == 2'd0) return (o == 3'd1) ? "R2/R5" : "R2/R6";
        if (md == 2'd1) return (o == 3'd1) ? "R3/R5" : "R3/R6";
        return (o == 3'd1) ? "R4/R5" : "R4/R6";
      end
      3'd3: return "R8";
      3'd4: return "R7";
      3'd5: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at the next falling edge
  task automatic do_op(input logic [2:0] o, input logic [1:0] md, input logic [1:0] s,
                       input logic [31:0] av, input logic [31:0] bv);
    string t;
    logic rd;
    t = tag_of(o, md);
    op = o; mode = md; sh = s; a = av; b = bv;
    rd = (o == 3'd5) || (o == 3'd6);
    case (o)
      3'd1: m_acc = mdl_prod(md, av, bv);
      3'd2: m_acc = (m_acc + mdl_prod(md, av, bv)) & MASK;
      3'd3: m_acc = ((m_acc + 64'h8000_0000) & MASK) & ~64'hFFFF_FFFF;
      3'd4: m_acc = ((m_acc + 64'h0000_8000) & MASK) & ~64'h0000_FFFF;
      3'd5: m_res = 32'((m_acc >> (16 - s)) & 64'hFFFF_FFFF);
      3'd6: m_res = m_acc[31:0];
      default: ;
    endcase
    @(negedge clk);
    check(t, "acc", {8'h0, acc}, m_acc);
    check(t, "res_vld", {63'h0, vld}, {63'h0, rd});
    check(t, "res", {32'h0, res}, {32'h0, m_res});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    m_acc = '0; m_res = '0;
    op = 3'd1; mode = 2'd0; a = 32'h7FFF_7FFF; b = 32'h7FFF_7FFF;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero even with a load requested
    check("R1", "acc in reset", {8'h0, acc}, 64'h0);
    check("R1", "res in reset", {32'h0, res}, 64'h0);
    check("R1", "vld in reset", {63'h0, vld}, 64'h0);
    op = 3'd0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][70:68], VEC[i][67:66], VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);

    // R2 hand value: (-1) x 1 at bits 47:16
    do_op(3'd1, 2'd0, 2'd0, 32'hFFFF_0000, 32'h0001_0000);
    check("R2", "neg half product", {8'h0, acc}, 64'h00FF_FFFF_FFFF_0000);
    do_op(3'd5, 2'd0, 2'd0, 32'h0, 32'h0);
    check("R9", "shifted read of -1", {32'h0, res}, 64'hFFFF_FFFF);

    // R7: exact halfway rounds up
    do_op(3'd1, 2'd3, 2'd0, 32'h0000_8000, 32'h0000_0001);
    do_op(3'd4, 2'd0, 2'd0, 32'h0, 32'h0);
    check("R7", "halfway up", {8'h0, acc}, 64'h0000_0000_0001_0000);

    // R8: just below halfway carries through to zero low part
    do_op(3'd1, 2'd3, 2'd0, 32'h7FFF_FFFF, 32'h0000_0001);
    do_op(3'd3, 2'd0, 2'd0, 32'h0, 32'h0);
    check("R8", "round 7fffffff", {8'h0, acc}, 64'h0000_0000_0000_0000);

    // R11: idle opcode 7 with busy operands
    do_op(3'd6, 2'd0, 2'd0, 32'h0, 32'h0);
    do_op(3'd7, 2'd3, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R11", "idle7 acc", {8'h0, acc}, 64'h0);

    // R6: wrap modulo 2^56 with no saturation: 512 x 2^46 = 2^55
    do_op(3'd1, 2'd3, 2'd0, 32'h8000_0000, 32'h0000_8000);
    for (int k = 0; k < 511; k++) begin
      op = 3'd2; mode = 2'd3; a = 32'h8000_0000; b = 32'h0000_8000;
      m_acc = (m_acc + mdl_prod(2'd3, a, b)) & MASK;
      @(negedge clk);
    end
    op = 3'd0;
    check("R6", "wrap to sign bit", {8'h0, acc}, 64'h0080_0000_0000_0000);
    @(negedge clk);

    // R1: mid-run reset clears state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = '0; m_res = '0;
    @(negedge clk);
    check("R1", "acc after reset", {8'h0, acc}, 64'h0);
    check("R1", "vld after reset", {63'h0, vld}, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule